// File: doc/BRIEF.md
# Inter-core interrupt and mailbox register block

This block is the per-core register set that lets one processor core signal another and hand over start-up parameters. Other cores, or the same core, reach it through a small memory-mapped slave port. A 32-bit pending word holds one bit per interrupt cause. Software cannot write that word directly. Bits are raised by writing ones to a set address and lowered by writing ones to a clear address. A 32-bit mask selects which pending bits may interrupt the core. The block drives one level-sensitive interrupt line.

Four 64-bit mailbox registers carry parameters, such as an entry address, from the boot core to a waiting core. Each mailbox can be accessed as a whole 64-bit word. It can also be accessed one 32-bit half at a time, so narrow masters can use it. Reads are combinational from the current port inputs. Writes take effect at the clock edge.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset the pending word, the mask and all four mailboxes read as zero, and `irq_out` is low.
- R2: The pending word reads at offset 0x00 and is read-only. A write to 0x00 changes no state.
- R3: The mask reads and writes at offset 0x04, using `bus_wdata[31:0]`. Each bit of `bus_be[3:0]` enables one byte lane, with lane n covering bits 8n+7..8n.
- R4: A write to offset 0x08 sets each pending bit whose data bit is 1 in an enabled byte lane. All other pending bits are unchanged.
- R5: A write to offset 0x0C clears each pending bit whose data bit is 1 in an enabled byte lane. All other pending bits are unchanged.
- R6: `irq_out` is a register that goes high when any bit is 1 in both the pending word and the mask. A write that changes this condition becomes visible on `irq_out` one clock after the edge that takes the write.
- R7: Mailbox k sits at offset 0x20 + 8k, selected by `bus_addr[4:3]`. When `bus_wide` = 1, an access moves all 64 bits, and `bus_be[7:0]` enables its eight byte lanes.
- R8: When `bus_wide` = 0, a mailbox access reaches the upper half if `bus_addr[2]` = 1 and the lower half otherwise. Narrow write data comes from `bus_wdata[31:0]` under `bus_be[3:0]`, and the other half is left unchanged. A narrow read returns the half in bits 31:0, with bits 63:32 zero.
- R9: Reads at 0x08, 0x0C and 0x10–0x1F return zero. Writes to 0x10–0x1F change no state. Address bits 1:0 are ignored.
- R10: `bus_rdata` is zero in every cycle where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset within the block |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 8 | Byte lane enables |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data |
| irq_out | output | 1 | Level interrupt to the core |

## Verification
The hardest case to reach from the ports is a narrow write that must leave the other half of a mailbox intact. It is hardest when it meets partial byte strobes, or a wide write to the same mailbox just before or after it. The stimulus first places known patterns in every mailbox with wide writes. It then overwrites single halves and single bytes, and reads each mailbox back both whole and by halves. A long mixed phase follows, with random offsets, widths and strobes, and a cycle-accurate model compared on every clock. That phase also drives the interrupt through the case where a mask write, rather than a pending change, moves the output.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int NW = 32,
  parameter int MW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    bus_addr,
  input  logic          bus_wide,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [MW/8-1:0] bus_be,
  input  logic [MW-1:0] bus_wdata,
  output logic [MW-1:0] bus_rdata,
  output logic          irq_out
);
  localparam int NMB = 4;
  localparam int HW  = MW / 2;

  function automatic logic [MW-1:0] lanes(input logic [MW/8-1:0] be);
    for (int b = 0; b < MW/8; b++) lanes[b*8 +: 8] = {8{be[b]}};
  endfunction

  logic [NW-1:0] pend, mask;
  logic [MW-1:0] mbox [NMB];
  logic          irq_q;
  logic [MW-1:0] rd_val, sel_mb;

  wire [3:0]    reg_sel  = bus_addr[5:2];
  wire [MW-1:0] full_m   = lanes(bus_be);
  wire [NW-1:0] lo_m     = full_m[NW-1:0];
  wire [NW-1:0] wbits    = bus_wdata[NW-1:0] & lo_m;
  wire          do_set   = bus_wr && reg_sel == 4'h2;
  wire          do_clr   = bus_wr && reg_sel == 4'h3;
  wire          do_mask  = bus_wr && reg_sel == 4'h1;
  wire [MW-1:0] mb_m     = bus_wide ? full_m :
                           bus_addr[2] ? {full_m[HW-1:0], {HW{1'b0}}} : {{HW{1'b0}}, full_m[HW-1:0]};
  wire [MW-1:0] mb_d     = bus_wide ? bus_wdata : {bus_wdata[HW-1:0], bus_wdata[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      irq_q <= 1'b0;
      for (int i = 0; i < NMB; i++) mbox[i] <= '0;
    end else begin
      irq_q <= |(pend & mask);
      if (do_set) pend <= pend | wbits;
      else if (do_clr) pend <= pend & ~wbits;
      if (do_mask) mask <= (mask & ~lo_m) | wbits;
      for (int i = 0; i < NMB; i++)
        if (bus_wr && bus_addr[5] && bus_addr[4:3] == i[1:0])
          mbox[i] <= (mbox[i] & ~mb_m) | (mb_d & mb_m);
    end
  end

  always_comb begin
    rd_val = '0;
    sel_mb = mbox[bus_addr[4:3]];
    if (bus_addr[5])
      rd_val = bus_wide ? sel_mb : {{HW{1'b0}}, bus_addr[2] ? sel_mb[MW-1:HW] : sel_mb[HW-1:0]};
    else if (reg_sel == 4'h0)
      rd_val = {{(MW-NW){1'b0}}, pend};
    else if (reg_sel == 4'h1)
      rd_val = {{(MW-NW){1'b0}}, mask};
  end

  assign bus_rdata = bus_rd ? rd_val : '0;
  assign irq_out   = irq_q;

  assert_status_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && reg_sel == 4'h0 |=> pend == $past(pend) && mask == $past(mask));
  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> (pend & $past(wbits)) == $past(wbits) &&
               (pend & ~$past(wbits)) == ($past(pend) & ~$past(wbits)));
  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (pend & $past(wbits)) == '0 &&
               (pend & ~$past(wbits)) == ($past(pend) & ~$past(wbits)));
  assert_mbox_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[5] |=> $stable(pend) && $stable(mask));
  assert_hole_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[5:4] == 2'b01 |=> $stable(pend) && $stable(mask) && $stable(irq_q) == $stable(irq_q));
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

// File: tb/ipi_mailbox_bench.sv
`timescale 1ns/1ps
module ipi_mailbox_bench;
  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = 0;
  logic bus_wide = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_be = 0;
  logic [63:0] bus_wdata = 0, bus_rdata;
  logic irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  ipi_mailbox u_ipi_mailbox (.clk, .rst_n, .bus_addr, .bus_wide, .bus_wr, .bus_rd,
    .bus_be, .bus_wdata, .bus_rdata, .irq_out);

  always #5 clk = ~clk;

  // behavioural reference
  logic [31:0] m_st, m_en;
  logic [63:0] m_mb [4];
  logic m_irq;

  function automatic logic [63:0] bm(input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = be[b] ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] m_read(input logic [5:0] a, input logic w);
    int k;
    k = a[4:3];
    if (a >= 6'h20) return w ? m_mb[k] : {32'h0, a[2] ? m_mb[k][63:32] : m_mb[k][31:0]};
    if (a[5:2] == 0) return {32'h0, m_st};
    if (a[5:2] == 1) return {32'h0, m_en};
    return 64'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_en <= 0; m_irq <= 0;
      for (int i = 0; i < 4; i++) m_mb[i] <= 0;
    end else begin
      logic [63:0] msk, d;
      int k;
      m_irq <= (m_st & m_en) != 0;
      msk = bm(bus_be);
      k = bus_addr[4:3];
      if (bus_wr) begin
        case (bus_addr[5:2])
          4'd1: m_en <= (m_en & ~msk[31:0]) | (bus_wdata[31:0] & msk[31:0]);
          4'd2: m_st <= m_st | (bus_wdata[31:0] & msk[31:0]);
          4'd3: m_st <= m_st & ~(bus_wdata[31:0] & msk[31:0]);
          default: if (bus_addr[5]) begin
            if (bus_wide) d = bus_wdata;
            else begin
              d = {bus_wdata[31:0], bus_wdata[31:0]};
              msk = bus_addr[2] ? {msk[31:0], 32'h0} : {32'h0, msk[31:0]};
            end
            m_mb[k] <= (m_mb[k] & ~msk) | (d & msk);
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare on every clock
  always @(negedge clk) if (rst_n && !done) begin
    chk(irq_out === m_irq, "R6 irq", {63'h0, irq_out}, {63'h0, m_irq});
    if (bus_rd) chk(bus_rdata === m_read(bus_addr, bus_wide), "R7 R8 R9 read vs model", bus_rdata, m_read(bus_addr, bus_wide));
    else chk(bus_rdata === 64'h0, "R10 idle rdata", bus_rdata, 0);
  end

  task automatic wr(input logic [5:0] a, input logic w, input logic [7:0] be, input logic [63:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wide = w; bus_be = be; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic w, input logic [63:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wide = w; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(irq_out === 0, "R1 irq after reset", {63'h0, irq_out}, 0);
    rd(6'h00, 0, 0, "R1 pending reset");
    rd(6'h04, 0, 0, "R1 mask reset");
    rd(6'h20, 1, 0, "R1 mailbox reset");
    rd(6'h38, 1, 0, "R1 mailbox3 reset");

    wr(6'h04, 0, 8'h0F, 64'h0000_FFFF);
    rd(6'h04, 0, 64'h0000_FFFF, "R3 mask write");
    wr(6'h04, 0, 8'h08, 64'hAB12_3456);
    rd(6'h04, 0, 64'hAB00_FFFF, "R3 mask byte lane");

    wr(6'h08, 0, 8'h0F, 64'h0001_0003);
    rd(6'h00, 0, 64'h0001_0003, "R4 set");
    chk(irq_out === 1, "R6 irq raised", {63'h0, irq_out}, 1);
    wr(6'h00, 0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h00, 0, 64'h0001_0003, "R2 pending read-only");
    wr(6'h0C, 0, 8'h0F, 64'h1);
    rd(6'h00, 0, 64'h0001_0002, "R5 clear");
    wr(6'h08, 0, 8'h04, 64'hFFFF_FFFF);
    rd(6'h00, 0, 64'h00FF_0002, "R4 set byte lane");
    wr(6'h0C, 0, 8'h01, 64'hFFFF_FFFF);
    @(negedge clk);
    chk(irq_out === 1, "R6 one-cycle latency", {63'h0, irq_out}, 1);
    @(negedge clk);
    chk(irq_out === 0, "R6 irq dropped", {63'h0, irq_out}, 0);
    rd(6'h00, 0, 64'h00FF_0000, "R5 clear byte lane");

    wr(6'h20, 1, 8'hFF, 64'h0123_4567_89AB_CDEF);
    wr(6'h28, 1, 8'hFF, 64'hFEDC_BA98_7654_3210);
    wr(6'h30, 1, 8'hFF, 64'h0F0F_0F0F_0F0F_0F0F);
    wr(6'h38, 1, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    rd(6'h20, 1, 64'h0123_4567_89AB_CDEF, "R7 mailbox0");
    rd(6'h28, 1, 64'hFEDC_BA98_7654_3210, "R7 mailbox1");
    rd(6'h30, 1, 64'h0F0F_0F0F_0F0F_0F0F, "R7 mailbox2");
    rd(6'h38, 1, 64'hDEAD_BEEF_CAFE_F00D, "R7 mailbox3");
    wr(6'h2C, 0, 8'h0F, 64'h1122_3344);
    rd(6'h28, 0, 64'h7654_3210, "R8 narrow lower kept");
    rd(6'h2C, 0, 64'h1122_3344, "R8 narrow upper");
    rd(6'h28, 1, 64'h1122_3344_7654_3210, "R8 wide after narrow");
    wr(6'h30, 0, 8'h0F, 64'hAAAA_AAAA);
    rd(6'h30, 1, 64'h0F0F_0F0F_AAAA_AAAA, "R8 narrow lower");
    wr(6'h38, 1, 8'h0F, 64'h0);
    rd(6'h38, 1, 64'hDEAD_BEEF_0000_0000, "R7 wide byte lanes");

    rd(6'h08, 0, 0, "R9 set reads zero");
    rd(6'h0C, 0, 0, "R9 clear reads zero");
    wr(6'h10, 1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h10, 1, 0, "R9 hole reads zero");
    rd(6'h1C, 0, 0, "R9 hole reads zero");
    rd(6'h00, 0, 64'h00FF_0000, "R9 hole write ignored");
    rd(6'h06, 0, 64'hAB00_FFFF, "R9 low address bits ignored");
    @(negedge clk);
    chk(bus_rdata === 0, "R10 rdata idle", bus_rdata, 0);

    for (int n = 0; n < 2000; n++) begin
      logic [5:0] a;
      a = 6'($urandom) & 6'h3C;
      if ($urandom % 2) wr(a, 1'($urandom), 8'($urandom), {$urandom, $urandom});
      else begin
        @(posedge clk); #1;
        bus_addr = a; bus_wide = 1'($urandom); bus_rd = 1;
        @(posedge clk); #1;
        bus_rd = 0;
      end
    end
    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule